// File: doc/BRIEF.md
# Dual-View GPIO Controller with Per-Line Ownership

This block is a 32-line general-purpose I/O controller with a word-indexed 32-bit register bus. It offers two register views, each with its own set of registers. One view can always be reached. The other, the privileged view, can be reached only while an external permission input is high. A per-line owner word decides which view drives each line's output value and direction. It also decides which view's interrupt logic watches that line.

Incoming pin levels pass through a two-stage synchroniser. Each view compares the synchronised level against a programmable per-line polarity and latches a sticky flag when the two match. The flags are combined with a per-view mask into one level-sensitive interrupt request per view. Software clears a flag by writing a one to its bit. Pad buffers, the permission firewall and any edge emulation done by host software sit outside this block.

Top module: `gpio_dual_view`

## Requirements
- R1: The bus address is a 4-bit word index. Bit 3 selects the view (0 = general, 1 = privileged) and bits 2:0 select the slot: 0 output, 1 direction, 2 input, 3 interrupt polarity, 4 interrupt flag, 5 interrupt mask, 6 input mirror. Slot 7 is the enable word in the general half and the owner word in the privileged half. Bit n of every word is line n.
- R2: `pinOut[n]` and `pinOe[n]` come from the general view's output and direction bits when owner bit n is 1, and from the privileged view's bits when it is 0. A direction value of 1 means the line drives.
- R3: Privileged words (word index 7 and above) read as zero, and ignore writes, while `permit` is low. The general view is reachable regardless of `permit`.
- R4: In each view, the output, direction, flag and mask words read zero for lines that view does not own, and writes to those bits have no effect. A view holds no flags for lines it does not own.
- R5: Pins pass through two flip-flops. A pin value driven before a clock edge is returned by the input and mirror slots of both views after the second edge.
- R6: A view's flag bit n sets on the edge after the synchronised level of line n equals that view's polarity bit n (1 = active high, 0 = active low), provided the view owns the line. The flag then stays set.
- R7: Writing 1 to a flag bit clears it for one cycle. If the level still matches, the flag sets again on the following edge. Writing 0 to a flag bit has no effect.
- R8: `irqGen` and `irqPriv` are each high exactly when that view has a bit set in flag AND mask on a line it owns.
- R9: After reset, the owner word is zero, so every line belongs to the privileged view. Direction, output, polarity, flag, mask and enable words are zero.
- R10: The enable word is a 32-bit read/write word that is reachable only through privileged access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| permit | input | 1 | Grants access to the privileged words |
| busSel | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Word index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the index |
| pinIn | input | 32 | Asynchronous pin levels |
| pinOut | output | 32 | Output value for each line |
| pinOe | output | 32 | Drive enable for each line |
| irqGen | output | 1 | Interrupt request from the general view |
| irqPriv | output | 1 | Interrupt request from the privileged view |

## Verification
The hardest case to reach is a line whose owner changes while it holds a pending, unmasked flag. To get there, the stimulus first withdraws `permit` and confirms that the privileged request line stays up. It then restores `permit` and rewrites the owner word. The request of the view that lost the line must drop, and its flag must not reappear in the new view. Re-arming after a clear needs the pin level held steady across the clear write, so the bench measures the one-cycle gap right after that write's edge. A behavioural reference model advances on every edge and is compared against the pins and both requests in every cycle.

// File: rtl/gpio_dv_pkg.sv
package gpio_dv_pkg;
  localparam int IDX_W = 4;
  localparam int NVIEW = 2;

  typedef enum logic [2:0] {
    SLOT_OUT    = 3'd0,
    SLOT_DIR    = 3'd1,
    SLOT_IN     = 3'd2,
    SLOT_POL    = 3'd3,
    SLOT_FLAG   = 3'd4,
    SLOT_MASK   = 3'd5,
    SLOT_MIRROR = 3'd6,
    SLOT_SPEC   = 3'd7
  } slotE;

  // strobes from control to datapath, one bit per view where per-view
  typedef struct packed {
    logic [NVIEW-1:0] wrOut;
    logic [NVIEW-1:0] wrDir;
    logic [NVIEW-1:0] wrPol;
    logic [NVIEW-1:0] wrClr;
    logic [NVIEW-1:0] wrMask;
    logic             wrEnable;
    logic             wrOwner;
    logic             rdAllowed;
  } strobeT;
endpackage

// File: rtl/gpio_dv_sync.sv
module gpio_dv_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) stageQ[0] <= '0;
          else       stageQ[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/gpio_dv_ctrl.sv
module gpio_dv_ctrl
  import gpio_dv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             permit,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [IDX_W-1:0] busAddr,
  output strobeT           strb
);
  logic privTarget;
  logic accessOk;
  logic wrGo;
  logic view;
  slotE slot;

  assign view       = busAddr[IDX_W-1];
  assign slot       = slotE'(busAddr[2:0]);
  assign privTarget = view | (slot == SLOT_SPEC);
  assign accessOk   = ~privTarget | permit;
  assign wrGo       = busSel & busWrite & accessOk;

  always_comb begin
    strb = '0;
    for (int v = 0; v < NVIEW; v++) begin
      if (wrGo && (view == v[0])) begin
        strb.wrOut[v]  = (slot == SLOT_OUT);
        strb.wrDir[v]  = (slot == SLOT_DIR);
        strb.wrPol[v]  = (slot == SLOT_POL);
        strb.wrClr[v]  = (slot == SLOT_FLAG);
        strb.wrMask[v] = (slot == SLOT_MASK);
      end
    end
    strb.wrEnable  = wrGo & ~view & (slot == SLOT_SPEC);
    strb.wrOwner   = wrGo &  view & (slot == SLOT_SPEC);
    strb.rdAllowed = accessOk;
  end

  // R3: no privileged write strobe leaves control while permission is low
  assert_no_priv_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    !permit |-> !(strb.wrOwner | strb.wrEnable | strb.wrOut[1] | strb.wrDir[1] |
                  strb.wrPol[1] | strb.wrClr[1] | strb.wrMask[1]));

  // R1: at most one register is written per access
  assert_one_target_R1: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.wrOut, strb.wrDir, strb.wrPol, strb.wrClr, strb.wrMask,
                strb.wrEnable, strb.wrOwner}) <= 1);
endmodule

// File: rtl/gpio_dv_datapath.sv
module gpio_dv_datapath
  import gpio_dv_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strb,
  input  logic [IDX_W-1:0] busAddr,
  input  logic [LINES-1:0] busWdata,
  input  logic [LINES-1:0] syncIn,
  output logic [LINES-1:0] rdData,
  output logic [LINES-1:0] pinOut,
  output logic [LINES-1:0] pinOe,
  output logic [NVIEW-1:0] irq
);
  logic [LINES-1:0] ownerQ, enableQ;
  logic [LINES-1:0] outQ  [NVIEW];
  logic [LINES-1:0] dirQ  [NVIEW];
  logic [LINES-1:0] polQ  [NVIEW];
  logic [LINES-1:0] flagQ [NVIEW];
  logic [LINES-1:0] maskQ [NVIEW];

  logic [LINES-1:0] ownMask  [NVIEW];
  logic [LINES-1:0] outNext  [NVIEW];
  logic [LINES-1:0] dirNext  [NVIEW];
  logic [LINES-1:0] polNext  [NVIEW];
  logic [LINES-1:0] flagNext [NVIEW];
  logic [LINES-1:0] maskNext [NVIEW];
  logic [LINES-1:0] clrBits  [NVIEW];
  logic [LINES-1:0] hitBits  [NVIEW];

  generate
    for (genvar v = 0; v < NVIEW; v++) begin : g_view
      // view 0 owns the lines whose owner bit is 1
      if (v == 0) begin : g_gen
        assign ownMask[v] = ownerQ;
      end else begin : g_priv
        assign ownMask[v] = ~ownerQ;
      end
      assign irq[v] = |(flagQ[v] & maskQ[v] & ownMask[v]);
    end
  endgenerate

  always_comb begin
    for (int v = 0; v < NVIEW; v++) begin
      outNext[v]  = strb.wrOut[v]  ? ((outQ[v]  & ~ownMask[v]) | (busWdata & ownMask[v])) : outQ[v];
      dirNext[v]  = strb.wrDir[v]  ? ((dirQ[v]  & ~ownMask[v]) | (busWdata & ownMask[v])) : dirQ[v];
      maskNext[v] = strb.wrMask[v] ? ((maskQ[v] & ~ownMask[v]) | (busWdata & ownMask[v])) : maskQ[v];
      polNext[v]  = strb.wrPol[v]  ? busWdata : polQ[v];
      hitBits[v]  = ownMask[v] & ~(syncIn ^ polQ[v]);
      clrBits[v]  = strb.wrClr[v]  ? busWdata : '0;
      flagNext[v] = (flagQ[v] | hitBits[v]) & ~clrBits[v] & ownMask[v];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownerQ  <= '0;
      enableQ <= '0;
      for (int v = 0; v < NVIEW; v++) begin
        outQ[v]  <= '0;
        dirQ[v]  <= '0;
        polQ[v]  <= '0;
        flagQ[v] <= '0;
        maskQ[v] <= '0;
      end
    end else begin
      if (strb.wrOwner)  ownerQ  <= busWdata;
      if (strb.wrEnable) enableQ <= busWdata;
      for (int v = 0; v < NVIEW; v++) begin
        outQ[v]  <= outNext[v];
        dirQ[v]  <= dirNext[v];
        polQ[v]  <= polNext[v];
        flagQ[v] <= flagNext[v];
        maskQ[v] <= maskNext[v];
      end
    end
  end

  // read mux
  logic rdView;
  slotE rdSlot;
  assign rdView = busAddr[IDX_W-1];
  assign rdSlot = slotE'(busAddr[2:0]);

  always_comb begin
    rdData = '0;
    if (strb.rdAllowed) begin
      unique case (rdSlot)
        SLOT_OUT:    rdData = outQ[rdView]  & ownMask[rdView];
        SLOT_DIR:    rdData = dirQ[rdView]  & ownMask[rdView];
        SLOT_IN:     rdData = syncIn;
        SLOT_POL:    rdData = polQ[rdView];
        SLOT_FLAG:   rdData = flagQ[rdView] & ownMask[rdView];
        SLOT_MASK:   rdData = maskQ[rdView] & ownMask[rdView];
        SLOT_MIRROR: rdData = syncIn;
        SLOT_SPEC:   rdData = rdView ? ownerQ : enableQ;
        default:     rdData = '0;
      endcase
    end
  end

  assign pinOut = (outQ[0] & ownerQ) | (outQ[1] & ~ownerQ);
  assign pinOe  = (dirQ[0] & ownerQ) | (dirQ[1] & ~ownerQ);

  // R4: a newly risen flag bit belonged to that view on the previous cycle
  assert_flag_owned_gen_R4: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ[0] & ~$past(flagQ[0]) & ~$past(ownerQ)) == '0);
  assert_flag_owned_priv_R4: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ[1] & ~$past(flagQ[1]) & $past(ownerQ)) == '0);

  // R6: a flag only rises where level matched polarity on the previous cycle
  assert_flag_level_gen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ[0] & ~$past(flagQ[0]) & ($past(syncIn) ^ $past(polQ[0]))) == '0);
  assert_flag_level_priv_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ[1] & ~$past(flagQ[1]) & ($past(syncIn) ^ $past(polQ[1]))) == '0);

  // R7: bits written with one are clear on the next cycle
  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((flagQ[0] & $past(clrBits[0])) | (flagQ[1] & $past(clrBits[1]))) == '0);

  // R8: a request needs a masked flag on an owned line
  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq[0] |-> ((flagQ[0] & maskQ[0] & ownerQ) != '0));
endmodule

// File: rtl/gpio_dual_view.sv
module gpio_dual_view
  import gpio_dv_pkg::*;
#(
  parameter int LINES = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             permit,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [IDX_W-1:0] busAddr,
  input  logic [LINES-1:0] busWdata,
  output logic [LINES-1:0] busRdata,
  input  logic [LINES-1:0] pinIn,
  output logic [LINES-1:0] pinOut,
  output logic [LINES-1:0] pinOe,
  output logic             irqGen,
  output logic             irqPriv
);
  strobeT           strb;
  logic [LINES-1:0] syncIn;
  logic [NVIEW-1:0] irq;

  gpio_dv_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(pinIn), .syncOut(syncIn)
  );

  gpio_dv_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .permit(permit), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .strb(strb)
  );

  gpio_dv_datapath #(.LINES(LINES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busWdata(busWdata), .syncIn(syncIn), .rdData(busRdata),
    .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  assign irqGen  = irq[0];
  assign irqPriv = irq[1];

  // R3: privileged reads give zero without permission
  assert_priv_read_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!permit && (busAddr[IDX_W-1] || busAddr[2:0] == 3'd7)) |-> (busRdata == '0));
endmodule

// File: tb/gpio_dual_view_tb_top.sv
`timescale 1ns/1ps
module gpio_dual_view_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        permit = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinOe;
  logic        irqGen, irqPriv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_dual_view dut_i (
    .clk(clk), .rstN(rstN), .permit(permit), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .irqGen(irqGen), .irqPriv(irqPriv)
  );

  // behavioural reference: index 0 = general view, 1 = privileged view
  logic [31:0] mOut [2], mDir [2], mPol [2], mFlag [2], mMask [2];
  logic [31:0] mOwn, mEn, mS1, mS2;
  logic [31:0] nOut [2], nDir [2], nPol [2], nFlag [2], nMask [2];

  function automatic logic [31:0] viewOwn(int v);
    return (v == 0) ? mOwn : ~mOwn;
  endfunction

  function automatic logic [31:0] modelRead(logic [3:0] idx, logic perm);
    int v = idx[3] ? 1 : 0;
    logic [31:0] o = viewOwn(v);
    if ((idx[3] || idx[2:0] == 3'd7) && !perm) return 32'h0;
    case (idx[2:0])
      3'd0: return mOut[v] & o;
      3'd1: return mDir[v] & o;
      3'd2: return mS2;
      3'd3: return mPol[v];
      3'd4: return mFlag[v] & o;
      3'd5: return mMask[v] & o;
      3'd6: return mS2;
      default: return idx[3] ? mOwn : mEn;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int v = 0; v < 2; v++) begin
        mOut[v] = 0; mDir[v] = 0; mPol[v] = 0; mFlag[v] = 0; mMask[v] = 0;
      end
      mOwn = 0; mEn = 0; mS1 = 0; mS2 = 0;
    end else begin
      bit ok;
      bit wr;
      ok = !(busAddr[3] || busAddr[2:0] == 3'd7) || permit;
      wr = busSel && busWrite && ok;
      for (int v = 0; v < 2; v++) begin
        logic [31:0] o, clr;
        bit here;
        o = viewOwn(v);
        here = wr && (busAddr[3] == (v == 1));
        clr = (here && busAddr[2:0] == 3'd4) ? busWdata : 32'h0;
        nFlag[v] = (mFlag[v] | (o & ~(mS2 ^ mPol[v]))) & ~clr & o;
        nOut[v]  = (here && busAddr[2:0] == 3'd0) ? ((mOut[v]  & ~o) | (busWdata & o)) : mOut[v];
        nDir[v]  = (here && busAddr[2:0] == 3'd1) ? ((mDir[v]  & ~o) | (busWdata & o)) : mDir[v];
        nMask[v] = (here && busAddr[2:0] == 3'd5) ? ((mMask[v] & ~o) | (busWdata & o)) : mMask[v];
        nPol[v]  = (here && busAddr[2:0] == 3'd3) ? busWdata : mPol[v];
      end
      for (int v = 0; v < 2; v++) begin
        mFlag[v] = nFlag[v]; mOut[v] = nOut[v]; mDir[v] = nDir[v];
        mMask[v] = nMask[v]; mPol[v] = nPol[v];
      end
      if (wr && busAddr == 4'd15) mOwn = busWdata;
      if (wr && busAddr == 4'd7)  mEn  = busWdata;
      mS2 = mS1;
      mS1 = pinIn;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R2 pinOut model", pinOut, (mOut[0] & mOwn) | (mOut[1] & ~mOwn));
      chk("R2 pinOe model", pinOe, (mDir[0] & mOwn) | (mDir[1] & ~mOwn));
      chk("R8 irq model", {30'h0, irqPriv, irqGen},
          {30'h0, |(mFlag[1] & mMask[1] & ~mOwn), |(mFlag[0] & mMask[0] & mOwn)});
    end
  end

  task automatic wrReg(logic [3:0] idx, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = idx; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic rdReg(logic [3:0] idx, logic [31:0] exp, string tag);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = idx;
    #1;
    chk(tag, busRdata, exp);
    chk({tag, " (model)"}, busRdata, modelRead(idx, permit));
    busSel = 0;
  endtask

  task automatic setPins(logic [31:0] p);
    @(negedge clk);
    pinIn = p;
  endtask

  task automatic waitEdges(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    permit = 1;
    // R9 reset state
    rdReg(4'd15, 32'h0, "R9 owner reset");
    rdReg(4'd9,  32'h0, "R9 priv dir reset");
    rdReg(4'd11, 32'h0, "R9 priv polarity reset");
    rdReg(4'd7,  32'h0, "R9 enable reset");
    chk("R9 pinOe reset", pinOe, 32'h0);

    // R3 writes without permission are dropped
    permit = 0;
    wrReg(4'd15, 32'hFFFF0000);
    rdReg(4'd15, 32'h0, "R3 owner read w/o permit");
    permit = 1;
    rdReg(4'd15, 32'h0, "R3 owner write ignored");

    // R1 / R2 / R4 ownership routing
    wrReg(4'd15, 32'h0000FFFF);
    rdReg(4'd15, 32'h0000FFFF, "R1 owner readback");
    wrReg(4'd0, 32'hFFFFFFFF);
    wrReg(4'd1, 32'hFFFFFFFF);
    rdReg(4'd0, 32'h0000FFFF, "R4 gen out masked to owned");
    wrReg(4'd8, 32'hAAAAAAAA);
    wrReg(4'd9, 32'hFFFFFFFF);
    rdReg(4'd8, 32'hAAAA0000, "R4 priv out masked to owned");
    @(negedge clk);
    chk("R2 pinOut mix", pinOut, 32'hAAAAFFFF);
    chk("R2 pinOe mix", pinOe, 32'hFFFFFFFF);

    // R5 synchroniser latency
    setPins(32'h12345678);
    rdReg(4'd2, 32'h0, "R5 input after one edge");
    rdReg(4'd2, 32'h12345678, "R5 input after two edges");
    rdReg(4'd6, 32'h12345678, "R5 gen mirror");
    rdReg(4'd14, 32'h12345678, "R5 priv mirror");

    // R6 active-low default: priv flags follow low pins on owned lines
    wrReg(4'd12, 32'hFFFFFFFF);
    rdReg(4'd12, 32'hEDCB0000, "R6 priv active-low flags");
    wrReg(4'd4, 32'hFFFFFFFF);
    rdReg(4'd4, 32'h0000A987, "R7 gen flags re-set after clear");

    // R6 active-high on line 0, R8 request timing
    wrReg(4'd3, 32'h00000001);
    wrReg(4'd4, 32'hFFFFFFFF);
    wrReg(4'd5, 32'h00000001);
    chk("R8 irqGen idle", {31'h0, irqGen}, 32'h0);
    setPins(32'h12345679);
    @(negedge clk);
    chk("R6 no flag after one edge", {31'h0, irqGen}, 32'h0);
    @(negedge clk);
    chk("R5 no flag after two edges", {31'h0, irqGen}, 32'h0);
    @(negedge clk);
    chk("R6 flag after three edges", {31'h0, irqGen}, 32'h1);

    // R7 write-0 no effect, write-1 gap then re-arm
    wrReg(4'd4, 32'h00000000);
    chk("R7 write zero keeps flag", {31'h0, irqGen}, 32'h1);
    wrReg(4'd4, 32'h00000001);
    chk("R7 cleared right after write", {31'h0, irqGen}, 32'h0);
    @(negedge clk);
    chk("R7 re-armed next cycle", {31'h0, irqGen}, 32'h1);
    setPins(32'h12345678);
    waitEdges(3);
    chk("R6 flag sticky after level leaves", {31'h0, irqGen}, 32'h1);
    wrReg(4'd4, 32'h00000001);
    @(negedge clk);
    chk("R7 stays clear without match", {31'h0, irqGen}, 32'h0);

    // R8 privileged request on line 20, active low
    wrReg(4'd12, 32'hFFFFFFFF);
    wrReg(4'd13, 32'h00100000);
    chk("R8 irqPriv idle", {31'h0, irqPriv}, 32'h0);
    setPins(32'h12245678);
    waitEdges(3);
    chk("R8 irqPriv raised", {31'h0, irqPriv}, 32'h1);

    // R3 permission low: reads zero, clear ignored, request unaffected
    permit = 0;
    rdReg(4'd12, 32'h0, "R3 priv flag read w/o permit");
    wrReg(4'd12, 32'hFFFFFFFF);
    @(negedge clk);
    chk("R3 clear ignored w/o permit", {31'h0, irqPriv}, 32'h1);
    rdReg(4'd2, 32'h12245678, "R3 gen view open w/o permit");
    permit = 1;

    // R4 ownership change drops the pending flag
    wrReg(4'd15, 32'hFFFFFFFF);
    chk("R4 irqPriv dropped after owner change", {31'h0, irqPriv}, 32'h0);
    rdReg(4'd8, 32'h0, "R4 priv owns nothing");
    rdReg(4'd12, 32'h0, "R4 priv flags gone");
    @(negedge clk);
    chk("R2 pinOut all general", pinOut, 32'h0000FFFF);

    // R10 enable word
    wrReg(4'd7, 32'hCAFEF00D);
    rdReg(4'd7, 32'hCAFEF00D, "R10 enable readback");
    permit = 0;
    wrReg(4'd7, 32'h0);
    rdReg(4'd7, 32'h0, "R10 enable hidden w/o permit");
    permit = 1;
    rdReg(4'd7, 32'hCAFEF00D, "R10 enable write ignored w/o permit");

    waitEdges(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule